// File: doc/BRIEF.md
# Multi-Layer Crossbar with Boot Remap

This block joins six requesting masters to five target slaves over a single-phase valid/ready request interface carrying address, write enable, write data and read data. A request and its read data complete in the same cycle that the chosen slave raises ready. Each master has its own address decoder, and all decoders apply one shared memory map of 1 MB windows selected by the top four address bits. Each slave has its own round-robin arbiter, so masters aimed at different slaves move in the same cycle. A grant stays fixed while the slave stalls.

Some master-to-slave paths are deliberately left unwired. A request on such a path, or to a hole in the map, never reaches a slave: it completes at once with an error flag and zero read data. Window 0 is the boot region. A pin captured while reset is held picks whether it shows the internal ROM or the external bus. A remap pulse later overlays internal SRAM0 on it, so exception vectors can be rewritten. Only reset clears the overlay.

Top module: `mlx_crossbar`

## Requirements
- R1: When slave s completes a transfer (s_valid and s_ready high), it carries the granted master's translated address, write enable and write data, and s_src holds that master's index. In the same cycle that master sees m_ready high, m_err low and m_rdata equal to the slave's s_rdata.
- R2: Window decoding uses address bits [23:20]. 0x2 goes to slave 0 (SRAM0), 0x3 to slave 1 (SRAM1), 0x4 and 0x5 to slave 2 (ROM and USB host registers), 0x6 to 0xE to slave 3 (external bus) and 0xF to slave 4 (peripherals). 0x1 is unmapped. Outside window 0 the address reaches the slave unchanged.
- R3: A request to an unmapped window or over an unwired path sees m_ready and m_err high in its first cycle, with m_rdata zero. No slave ever shows that master as s_src for it.
- R4: In every cycle, each slave that has at least one pending routable request raises s_valid, whatever the other slaves are doing.
- R5: While a master waits on a slave, at most NUM_M-1 transfers by other masters complete on that slave before its own.
- R6: If a slave has s_valid high and s_ready low, the next cycle it still has s_valid high with the same s_src.
- R7: The boot select value present in the last reset cycle decides window 0. With 0, window 0 goes to slave 2 with the top nibble rewritten to 0x4. With 1, it goes to slave 3 with 0x6. Changes on the pin after reset release have no effect.
- R8: After any cycle with remap_i high, window 0 goes to slave 0 with the top nibble rewritten to 0x2, until the next reset. Further remap pulses change nothing.
- R9: Connectivity: master 0 reaches slaves 0 to 3. Master 1 reaches all slaves. Master 2 reaches all slaves except slave 2. Masters 3, 4 and 5 reach only slaves 0, 1 and 3. Any other pairing is treated as in R3.
- R10: A slave never raises s_valid unless the master named by s_src has m_valid high. With no requests, every s_valid and m_ready stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| boot_sel_i | input | 1 | Boot memory select, captured while reset is held |
| remap_i | input | 1 | Remap command pulse |
| m_valid | input | 6 | Per-master request valid |
| m_addr | input | 144 | Per-master address, 24 bits each |
| m_we | input | 6 | Per-master write enable |
| m_wdata | input | 192 | Per-master write data, 32 bits each |
| m_ready | output | 6 | Per-master completion |
| m_rdata | output | 192 | Per-master read data, 32 bits each |
| m_err | output | 6 | Per-master error response |
| s_valid | output | 5 | Per-slave request valid |
| s_addr | output | 120 | Per-slave translated address, 24 bits each |
| s_we | output | 5 | Per-slave write enable |
| s_wdata | output | 160 | Per-slave write data, 32 bits each |
| s_src | output | 15 | Per-slave granted master index, 3 bits each |
| s_ready | input | 5 | Per-slave ready |
| s_rdata | input | 160 | Per-slave read data, 32 bits each |

## Verification
The bench builds the block with its default parameters: six masters, five slaves, 24-bit addresses, 32-bit data and the default connectivity mask. Random offsets are kept within 32 words of each window, so several masters often collide on one slave. This drives the round-robin bound and the stalled-grant hold hard, while other slaves serve in parallel. Both boot select values are covered, each before and after remap, together with a repeated remap pulse and pin changes after reset release. Every window and every unwired pairing is reachable from the random address mix.

// File: rtl/mlx_pkg.sv
package mlx_pkg;

  localparam int WIN_W = 4;
  localparam int SLV_W = 3;

  localparam logic [SLV_W-1:0] SL_SRAM0  = 3'd0;
  localparam logic [SLV_W-1:0] SL_SRAM1  = 3'd1;
  localparam logic [SLV_W-1:0] SL_ROMUSB = 3'd2;
  localparam logic [SLV_W-1:0] SL_EXTBUS = 3'd3;
  localparam logic [SLV_W-1:0] SL_PERIPH = 3'd4;

  localparam logic [WIN_W-1:0] WIN_SRAM0 = 4'h2;
  localparam logic [WIN_W-1:0] WIN_ROM   = 4'h4;
  localparam logic [WIN_W-1:0] WIN_EXT   = 4'h6;

  // One 5-bit row per master, bit s set when slave s is wired (master 0 lowest).
  localparam logic [29:0] CONN_DEFAULT = {5'b01011, 5'b01011, 5'b01011,
                                          5'b11011, 5'b11111, 5'b01111};

  typedef struct packed {
    logic             hit;
    logic [SLV_W-1:0] slv;
    logic [WIN_W-1:0] win;
  } route_t;

  // Shared memory map: window nibble -> target slave and rewritten window.
  function automatic route_t route_window(input logic [WIN_W-1:0] win,
                                          input logic boot_ext,
                                          input logic remapped);
    route_t r;
    r.hit = 1'b1;
    r.win = win;
    r.slv = SL_EXTBUS;
    case (win)
      4'h0: begin
        if (remapped) begin
          r.slv = SL_SRAM0;  r.win = WIN_SRAM0;
        end else if (boot_ext) begin
          r.slv = SL_EXTBUS; r.win = WIN_EXT;
        end else begin
          r.slv = SL_ROMUSB; r.win = WIN_ROM;
        end
      end
      4'h1:       r.hit = 1'b0;
      4'h2:       r.slv = SL_SRAM0;
      4'h3:       r.slv = SL_SRAM1;
      4'h4, 4'h5: r.slv = SL_ROMUSB;
      4'hF:       r.slv = SL_PERIPH;
      default:    r.slv = SL_EXTBUS;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/mlx_decoder.sv
module mlx_decoder #(
  parameter int AW = 24,
  parameter int NS = 5,
  parameter logic [NS-1:0] CONN_ROW = '1
) (
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          boot_ext_i,
  input  logic          remapped_i,
  output logic [NS-1:0] req_o,
  output logic          err_o,
  output logic [AW-1:0] addr_o
);
  import mlx_pkg::*;

  route_t rt;
  logic   path_open;
  logic   target_ok;

  assign rt        = route_window(addr_i[AW-1 -: WIN_W], boot_ext_i, remapped_i);
  assign path_open = CONN_ROW[rt.slv];
  assign target_ok = rt.hit && path_open;

  always_comb begin
    req_o = '0;
    if (valid_i && target_ok) req_o[rt.slv] = 1'b1;
  end

  assign err_o  = valid_i && !target_ok;
  assign addr_o = {rt.win, addr_i[AW-WIN_W-1:0]};

endmodule

// File: rtl/mlx_arbiter.sv
module mlx_arbiter #(
  parameter int NM = 6,
  localparam int MW = (NM > 1) ? $clog2(NM) : 1,
  localparam int CW = $clog2(NM + 1) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NM-1:0] req_i,
  input  logic          ready_i,
  output logic [NM-1:0] grant_o,
  output logic [MW-1:0] gidx_o,
  output logic          valid_o
);

  logic [MW-1:0] last_q, lock_idx_q, pick_idx;
  logic          lock_q, pick_found, hold;
  logic          xfer_done, xfer_stall;

  always_comb begin
    int cand;
    pick_found = 1'b0;
    pick_idx   = last_q;
    for (int i = 1; i <= NM; i++) begin
      cand = (int'(last_q) + i) % NM;
      if (!pick_found && req_i[cand]) begin
        pick_found = 1'b1;
        pick_idx   = MW'(cand);
      end
    end
  end

  assign hold       = lock_q && req_i[lock_idx_q];
  assign gidx_o     = hold ? lock_idx_q : pick_idx;
  assign valid_o    = hold || pick_found;
  assign grant_o    = valid_o ? (NM'(1) << gidx_o) : '0;
  assign xfer_done  = valid_o && ready_i;
  assign xfer_stall = valid_o && !ready_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_q     <= MW'(NM - 1);
      lock_q     <= 1'b0;
      lock_idx_q <= '0;
    end else if (xfer_done) begin
      last_q <= gidx_o;
      lock_q <= 1'b0;
    end else if (xfer_stall) begin
      lock_q     <= 1'b1;
      lock_idx_q <= gidx_o;
    end else begin
      lock_q <= 1'b0;
    end
  end

  // Wait counters: completions by others seen by each waiting requester.
  for (genvar m = 0; m < NM; m++) begin : g_wait
    logic [CW-1:0] others_q;
    always_ff @(posedge clk) begin
      if (!rst_n) others_q <= '0;
      else if (!req_i[m] || (xfer_done && gidx_o == MW'(m))) others_q <= '0;
      else if (xfer_done) others_q <= others_q + 1'b1;
    end
    assert_rr_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      others_q <= CW'(NM - 1));
  end

  assert_grant_to_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> req_i[gidx_o]);
  assert_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_i) |-> valid_o);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stall |=> (!req_i[$past(gidx_o)] || (valid_o && gidx_o == $past(gidx_o))));

endmodule

// File: rtl/mlx_bootmap.sv
module mlx_bootmap (
  input  logic clk,
  input  logic rst_n,
  input  logic boot_pin_i,
  input  logic remap_i,
  output logic boot_ext_o,
  output logic remapped_o
);

  logic boot_q, remap_q, live_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boot_q  <= boot_pin_i;
      remap_q <= 1'b0;
      live_q  <= 1'b0;
    end else begin
      live_q <= 1'b1;
      if (remap_i) remap_q <= 1'b1;
    end
  end

  assign boot_ext_o = boot_q;
  assign remapped_o = remap_q;

  assert_boot_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> $stable(boot_ext_o));
  assert_remap_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
    remap_i |=> remapped_o);
  assert_remap_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    remapped_o |=> remapped_o);

endmodule

// File: rtl/mlx_crossbar.sv
module mlx_crossbar #(
  parameter int NUM_M = 6,
  parameter int NUM_S = 5,
  parameter int AW    = 24,
  parameter int DW    = 32,
  parameter logic [NUM_M*NUM_S-1:0] CONN = mlx_pkg::CONN_DEFAULT,
  localparam int MW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                boot_sel_i,
  input  logic                remap_i,
  input  logic [NUM_M-1:0]    m_valid,
  input  logic [NUM_M*AW-1:0] m_addr,
  input  logic [NUM_M-1:0]    m_we,
  input  logic [NUM_M*DW-1:0] m_wdata,
  output logic [NUM_M-1:0]    m_ready,
  output logic [NUM_M*DW-1:0] m_rdata,
  output logic [NUM_M-1:0]    m_err,
  output logic [NUM_S-1:0]    s_valid,
  output logic [NUM_S*AW-1:0] s_addr,
  output logic [NUM_S-1:0]    s_we,
  output logic [NUM_S*DW-1:0] s_wdata,
  output logic [NUM_S*MW-1:0] s_src,
  input  logic [NUM_S-1:0]    s_ready,
  input  logic [NUM_S*DW-1:0] s_rdata
);

  logic boot_ext, remapped;

  mlx_bootmap u_boot (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_pin_i (boot_sel_i),
    .remap_i    (remap_i),
    .boot_ext_o (boot_ext),
    .remapped_o (remapped)
  );

  logic [NUM_S-1:0] dreq  [NUM_M];
  logic [AW-1:0]    daddr [NUM_M];
  logic [NUM_M-1:0] derr;
  logic [NUM_M-1:0] col_req [NUM_S];
  logic [NUM_M-1:0] gnt     [NUM_S];
  logic [MW-1:0]    gidx    [NUM_S];
  logic [NUM_S-1:0] slv_fire;

  for (genvar m = 0; m < NUM_M; m++) begin : g_dec
    mlx_decoder #(
      .AW       (AW),
      .NS       (NUM_S),
      .CONN_ROW (CONN[m*NUM_S +: NUM_S])
    ) u_dec (
      .valid_i    (m_valid[m]),
      .addr_i     (m_addr[m*AW +: AW]),
      .boot_ext_i (boot_ext),
      .remapped_i (remapped),
      .req_o      (dreq[m]),
      .err_o      (derr[m]),
      .addr_o     (daddr[m])
    );
  end

  for (genvar s = 0; s < NUM_S; s++) begin : g_slv
    for (genvar m = 0; m < NUM_M; m++) begin : g_col
      assign col_req[s][m] = dreq[m][s];
    end

    mlx_arbiter #(.NM(NUM_M)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (col_req[s]),
      .ready_i (s_ready[s]),
      .grant_o (gnt[s]),
      .gidx_o  (gidx[s]),
      .valid_o (s_valid[s])
    );

    assign slv_fire[s]             = s_valid[s] && s_ready[s];
    assign s_addr[s*AW +: AW]      = s_valid[s] ? daddr[gidx[s]] : '0;
    assign s_we[s]                 = s_valid[s] && m_we[gidx[s]];
    assign s_wdata[s*DW +: DW]     = s_valid[s] ? m_wdata[gidx[s]*DW +: DW] : '0;
    assign s_src[s*MW +: MW]       = gidx[s];

    assert_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      s_valid[s] |-> m_valid[gidx[s]]);

    for (genvar m = 0; m < NUM_M; m++) begin : g_pair
      assert_no_leak_R3: assert property (@(posedge clk) disable iff (!rst_n)
        m_err[m] |-> !(s_valid[s] && gidx[s] == MW'(m)));
      if (CONN[m*NUM_S + s] == 1'b0) begin : g_cut
        assert_unwired_R9: assert property (@(posedge clk) disable iff (!rst_n)
          !(s_valid[s] && gidx[s] == MW'(m)));
      end
    end
  end

  for (genvar m = 0; m < NUM_M; m++) begin : g_rsp
    logic          rsp_done;
    logic [DW-1:0] rsp_data;
    always_comb begin
      rsp_done = 1'b0;
      rsp_data = '0;
      for (int s = 0; s < NUM_S; s++) begin
        if (gnt[s][m] && s_ready[s]) begin
          rsp_done = 1'b1;
          rsp_data = s_rdata[s*DW +: DW];
        end
      end
    end
    assign m_ready[m]          = derr[m] || rsp_done;
    assign m_err[m]            = derr[m];
    assign m_rdata[m*DW +: DW] = derr[m] ? '0 : rsp_data;

    assert_err_is_instant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      m_err[m] |-> (m_ready[m] && !rsp_done));
  end

endmodule

// File: tb/mlx_crossbar_tb.sv
module mlx_crossbar_tb;
  localparam int NM = 6, NS = 5, AW = 24, DW = 32, MW = 3;

  logic clk = 1'b0, rst_n = 1'b0, boot_pin = 1'b0, remap_cmd = 1'b0;
  logic [NM-1:0]    m_valid = '0, m_we = '0, m_ready, m_err;
  logic [NM*AW-1:0] m_addr = '0;
  logic [NM*DW-1:0] m_wdata = '0, m_rdata;
  logic [NS-1:0]    s_valid, s_we, s_ready = '0;
  logic [NS*AW-1:0] s_addr;
  logic [NS*DW-1:0] s_wdata, s_rdata = '0;
  logic [NS*MW-1:0] s_src;

  always #4 clk = ~clk;

  mlx_crossbar u_dut (
    .clk(clk), .rst_n(rst_n), .boot_sel_i(boot_pin), .remap_i(remap_cmd),
    .m_valid(m_valid), .m_addr(m_addr), .m_we(m_we), .m_wdata(m_wdata),
    .m_ready(m_ready), .m_rdata(m_rdata), .m_err(m_err),
    .s_valid(s_valid), .s_addr(s_addr), .s_we(s_we), .s_wdata(s_wdata),
    .s_src(s_src), .s_ready(s_ready), .s_rdata(s_rdata)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [int];
  bit exp_boot_ext, exp_remap, rand_en;
  bit pend [NM];
  logic [AW-1:0] p_addr [NM];
  bit p_we [NM];
  logic [DW-1:0] p_wd [NM];
  int others [NM];
  logic [DW-1:0] last_rd [NM];
  bit last_err [NM];
  bit prev_stall [NS];
  int prev_src [NS];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit allowed(input int m, input int s);
    case (m)
      0: return s != 4;
      1: return 1'b1;
      2: return s != 2;
      default: return (s <= 1) || (s == 3);
    endcase
  endfunction

  // Bench-side map: returns slave index (-1 unmapped) and the slave-side address.
  function automatic int target(input logic [AW-1:0] a, output logic [AW-1:0] tr);
    int n = int'(a[AW-1:AW-4]);
    tr = a;
    if (n == 0) begin
      if (exp_remap) begin tr[AW-1:AW-4] = 4'h2; return 0; end
      if (exp_boot_ext) begin tr[AW-1:AW-4] = 4'h6; return 3; end
      tr[AW-1:AW-4] = 4'h4; return 2;
    end
    if (n == 1) return -1;
    if (n == 2) return 0;
    if (n == 3) return 1;
    if (n <= 5) return 2;
    if (n == 15) return 4;
    return 3;
  endfunction

  function automatic int mkey(input int s, input logic [AW-1:0] a);
    return s * (1 << 24) + int'(a);
  endfunction

  function automatic logic [31:0] rd(input int s, input logic [AW-1:0] a);
    int k = mkey(s, a);
    if (mem.exists(k)) return mem[k];
    return (32'(k) * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endfunction

  task automatic start_req(input int m, input logic [AW-1:0] a, input bit we,
                           input logic [DW-1:0] wd);
    pend[m] = 1'b1; p_addr[m] = a; p_we[m] = we; p_wd[m] = wd; others[m] = 0;
  endtask

  task automatic run_cycle();
    int src, slv;
    bit err;
    bit done [NM];
    logic [AW-1:0] tr;
    @(negedge clk);
    for (int m = 0; m < NM; m++) begin
      if (!pend[m] && rand_en && ($urandom % 3 == 0))
        start_req(m, {4'($urandom % 16), 20'($urandom % 32)}, 1'($urandom % 2), $urandom);
      m_valid[m] = pend[m];
      m_addr[m*AW +: AW] = p_addr[m];
      m_we[m] = pend[m] && p_we[m];
      m_wdata[m*DW +: DW] = p_wd[m];
    end
    for (int s = 0; s < NS; s++) s_ready[s] = ($urandom % 10) < 6;
    #1;
    for (int s = 0; s < NS; s++) s_rdata[s*DW +: DW] = rd(s, s_addr[s*AW +: AW]);
    #1;
    // Slave side: routing (R1, R2), hold (R6), wiring (R9), idle (R10)
    for (int s = 0; s < NS; s++) begin
      src = int'(s_src[s*MW +: MW]);
      if (prev_stall[s])
        chk(s_valid[s] && src == prev_src[s], "R6", "stalled grant moved", 64'(src), 64'(prev_src[s]));
      if (s_valid[s]) begin
        if (src < NM) begin
          slv = target(p_addr[src], tr);
          chk(pend[src], "R10", "slave valid without request", 64'(src), 64'(src));
          chk(slv == s && tr == s_addr[s*AW +: AW], "R2", "routed slave/address",
              {32'(s), 32'(s_addr[s*AW +: AW])}, {32'(slv), 32'(tr)});
          chk(s_we[s] == p_we[src] && (!p_we[src] || s_wdata[s*DW +: DW] == p_wd[src]), "R1",
              "write fields", {31'b0, s_we[s], s_wdata[s*DW +: DW]}, {31'b0, p_we[src], p_wd[src]});
          chk(allowed(src, s), "R9", "unwired path reached slave", 64'(src), 64'(s));
        end else begin
          chk(1'b0, "R1", "bad s_src", 64'(src), 64'(0));
        end
      end
      prev_stall[s] = s_valid[s] && !s_ready[s];
      prev_src[s] = src;
    end
    // Master side: results (R1, R3), concurrency (R4), fairness (R5)
    for (int m = 0; m < NM; m++) begin
      done[m] = 1'b0;
      if (!pend[m]) begin
        chk(!m_ready[m], "R10", "ready without request", 64'(m_ready[m]), 64'(0));
        continue;
      end
      slv = target(p_addr[m], tr);
      err = (slv < 0) || !allowed(m, slv);
      if (err) begin
        chk(m_ready[m] && m_err[m] && m_rdata[m*DW +: DW] == '0, "R3", "error response",
            {m_ready[m], m_err[m], 30'b0, m_rdata[m*DW +: DW]}, {2'b11, 62'b0});
        done[m] = 1'b1;
        last_err[m] = 1'b1;
        last_rd[m] = m_rdata[m*DW +: DW];
      end else begin
        chk(s_valid[slv], "R4", "slave idle with pending request", 64'(s_valid[slv]), 64'(1));
        if (m_ready[m]) begin
          chk(!m_err[m] && (p_we[m] || m_rdata[m*DW +: DW] == rd(slv, tr)), "R1", "read data",
              {31'b0, m_err[m], m_rdata[m*DW +: DW]}, {32'b0, rd(slv, tr)});
          done[m] = 1'b1;
          last_err[m] = m_err[m];
          last_rd[m] = m_rdata[m*DW +: DW];
        end else if (s_valid[slv] && s_ready[slv]) begin
          others[m]++;
          chk(others[m] <= NM - 1, "R5", "waiting master passed over", 64'(others[m]), 64'(NM - 1));
        end
      end
    end
    for (int s = 0; s < NS; s++)
      if (s_valid[s] && s_ready[s] && s_we[s])
        mem[mkey(s, s_addr[s*AW +: AW])] = s_wdata[s*DW +: DW];
    for (int m = 0; m < NM; m++) if (done[m]) pend[m] = 1'b0;
  endtask

  task automatic quiesce();
    bit busy;
    rand_en = 1'b0;
    do begin
      run_cycle();
      busy = 1'b0;
      for (int m = 0; m < NM; m++) busy |= pend[m];
    end while (busy);
  endtask

  task automatic access(input int m, input logic [AW-1:0] a, input bit we, input logic [DW-1:0] wd);
    start_req(m, a, we, wd);
    do run_cycle(); while (pend[m]);
  endtask

  task automatic do_reset(input bit pin);
    @(negedge clk);
    rst_n = 1'b0;
    boot_pin = pin;
    m_valid = '0;
    for (int m = 0; m < NM; m++) pend[m] = 1'b0;
    for (int s = 0; s < NS; s++) prev_stall[s] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk(s_valid == '0 && m_ready == '0, "R10", "outputs in reset", {s_valid, m_ready}, 64'(0));
    rst_n = 1'b1;
    exp_boot_ext = pin;
    exp_remap = 1'b0;
  endtask

  task automatic remap_pulse();
    @(negedge clk);
    remap_cmd = 1'b1;
    @(negedge clk);
    remap_cmd = 1'b0;
    exp_remap = 1'b1;
  endtask

  task automatic traffic(input int n);
    rand_en = 1'b1;
    repeat (n) run_cycle();
    quiesce();
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // Boot from internal ROM
    do_reset(1'b0);
    boot_pin = 1'b1; // R7: late change must be ignored
    access(1, 24'h000010, 1'b0, '0);
    chk(!last_err[1] && last_rd[1] == rd(2, 24'h400010), "R7", "boot window shows ROM",
        64'(last_rd[1]), 64'(rd(2, 24'h400010)));
    access(5, 24'hF00004, 1'b0, '0);
    chk(last_err[5] && last_rd[5] == '0, "R9", "network master to peripherals",
        {31'b0, last_err[5], last_rd[5]}, {31'b0, 1'b1, 32'b0});
    access(0, 24'h100000, 1'b0, '0);
    chk(last_err[0], "R3", "unmapped window", 64'(last_err[0]), 64'(1));
    access(2, 24'h400000, 1'b0, '0);
    chk(last_err[2], "R9", "dma master to ROM slave", 64'(last_err[2]), 64'(1));
    traffic(4000);
    access(1, 24'h200030, 1'b1, 32'hCAFE_0001);
    access(0, 24'h000030, 1'b0, '0);
    chk(last_rd[0] != 32'hCAFE_0001, "R7", "SRAM visible before remap", 64'(last_rd[0]), 64'(0));
    remap_pulse();
    access(0, 24'h000030, 1'b0, '0);
    chk(last_rd[0] == 32'hCAFE_0001, "R8", "SRAM0 at address zero", 64'(last_rd[0]), 64'hCAFE_0001);
    remap_pulse();
    access(0, 24'h000030, 1'b0, '0);
    chk(last_rd[0] == 32'hCAFE_0001, "R8", "second remap changes nothing", 64'(last_rd[0]), 64'hCAFE_0001);
    traffic(4000);
    // Boot from external bus
    do_reset(1'b1);
    boot_pin = 1'b0;
    access(1, 24'h000030, 1'b0, '0);
    chk(last_rd[1] == rd(3, 24'h600030) && last_rd[1] != 32'hCAFE_0001, "R7",
        "boot window shows external bus, remap cleared", 64'(last_rd[1]), 64'(rd(3, 24'h600030)));
    traffic(4000);
    remap_pulse();
    access(3, 24'h000030, 1'b0, '0);
    chk(last_rd[3] == 32'hCAFE_0001, "R8", "remap over external boot", 64'(last_rd[3]), 64'hCAFE_0001);
    traffic(4000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule